// File: doc/BRIEF.md
# Instruction Queue with Branch Folding

This block is an in-order instruction buffer placed between the instruction fetch path and the dispatch logic. Each cycle it tells the fetch path how many instructions it may deliver. It then accepts a group of up to four fetched instructions, each with a valid bit and three predecode flags. It offers its two oldest entries to dispatch. An entry leaves the queue only when its execution target is ready and the completion queue has granted a credit for it.

An unconditional taken branch that writes neither the count register nor the link register is folded when its group arrives. The branch never enters the queue, so it takes no dispatch slot and no completion entry. Every younger lane of the same group is discarded. A redirect pulse, carrying the branch word, tells the fetch path to fetch the target next. That target group then fills the slots that were left free.

A flush input empties the queue in one cycle. The queue holds six entries in strict program order, and older entries leaving at the bottom let the rest shift down into the dispatch positions.

Top module: `instr_queue_fold`

## Requirements
- R1: Out of reset the queue is empty: `disp_vld_o` is 0, `disp_go_o` is 0, `redirect_o` is 0 and `fetch_req_o` is 4.
- R2: `fetch_req_o` equals min(6 − occupancy, 4), where occupancy is the entry count held during the current cycle. It is therefore 0 when all six entries are full.
- R3: Of a fetch group, lane i (bit i of `fetch_vld_i`, word bits [32i+31:32i] of `fetch_word_i`) is accepted only if lanes 0..i are all valid and i < `fetch_req_o`. Every other lane is ignored. Accepted lanes are appended behind existing entries in lane order.
- R4: `disp_vld_o[k]` is 1 exactly when the queue holds more than k entries and flush is low. `disp_word_o[32k+31:32k]` then shows entry k, counted from the oldest.
- R5: Slot 0 dispatches (`disp_go_o[0]`) iff it is valid, `disp_rdy_i[0]` is 1 and `cq_free_i` ≥ 1. Slot 1 dispatches iff slot 0 dispatches, slot 1 is valid, `disp_rdy_i[1]` is 1 and `cq_free_i` ≥ 2.
- R6: Dispatched entries leave at the clock edge. The remaining entries move down by the number dispatched, and their order is kept.
- R7: A lane is foldable when its bit in `fetch_ubr_i` is 1 and its bits in `fetch_ctr_i` and `fetch_lr_i` are 0. The first foldable accepted lane is dropped together with every younger lane. In the same cycle `redirect_o` is 1 and `redirect_word_o` shows that lane's word.
- R8: A branch lane whose CTR or LR bit is 1 is not folded. It is queued and dispatched like any other instruction, and no redirect is raised for it.
- R9: While `flush_i` is 1, dispatch and redirect outputs are 0 and the fetch group is ignored. In the next cycle the queue is empty.
- R10: Occupancy never exceeds six, because no more than `fetch_req_o` lanes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the queue |
| fetch_vld_i | input | 4 | Per-lane valid of the fetch group |
| fetch_word_i | input | 128 | Four instruction words, lane 0 in the low bits |
| fetch_ubr_i | input | 4 | Per-lane: unconditional branch resolved taken |
| fetch_ctr_i | input | 4 | Per-lane: instruction writes the count register |
| fetch_lr_i | input | 4 | Per-lane: instruction writes the link register |
| fetch_req_o | output | 3 | Number of lanes the fetch path may deliver |
| cq_free_i | input | 2 | Completion-queue credits available this cycle (0..2) |
| disp_rdy_i | input | 2 | Per-slot: execution target can take the instruction |
| disp_vld_o | output | 2 | Per-slot: entry present for dispatch |
| disp_word_o | output | 64 | Words of the two oldest entries, slot 0 in the low bits |
| disp_go_o | output | 2 | Per-slot: instruction dispatched this cycle |
| redirect_o | output | 1 | A branch was folded; fetch the target next |
| redirect_word_o | output | 32 | Word of the folded branch |

## Verification
A miscounted occupancy shows on `fetch_req_o` in the same cycle whenever three or more entries are held. It shows on `disp_vld_o` once the queue drains below two. A wrong shift or append shows as a wrong word on `disp_word_o`, but only when that entry reaches one of the two bottom slots, up to three cycles later. For that reason the bench keeps a model of every entry and checks every bottom-slot word each cycle. A wrong fold decision shows at once on `redirect_o`. One cycle later it shows as an extra or missing word in the dispatch order.

// File: rtl/iqf_pkg.sv
// Package: shared word type and small helpers for the instruction queue.
// Assumes every instruction word has the same width.
package iqf_pkg;
    localparam int unsigned IW = 32;
    typedef logic [IW-1:0] word_t;

    // Smaller of two unsigned counts.
    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/iqf_fetch_scan.sv
// Module: iqf_fetch_scan
// Decides, for one incoming fetch group, how many lanes are written into
// the queue and whether a foldable branch terminates the group.
// Assumes lane 0 is the oldest lane and that req_i never exceeds FW.
module iqf_fetch_scan #(
    parameter int unsigned FW = 4,
    parameter int unsigned CW = 3,
    localparam int unsigned LW = (FW > 1) ? $clog2(FW) : 1
) (
    input  logic          flush_i,
    input  logic [FW-1:0] vld_i,
    input  logic [FW-1:0] ubr_i,
    input  logic [FW-1:0] ctr_i,
    input  logic [FW-1:0] lr_i,
    input  logic [CW-1:0] req_i,
    output logic [CW-1:0] wr_cnt_o,
    output logic          fold_o,
    output logic [LW-1:0] fold_lane_o
);
    logic          open;
    logic [CW-1:0] lead;
    logic          hit;
    logic [LW-1:0] lane;

    // Walk the lanes oldest first; stop at a gap, the request limit or a fold.
    always_comb begin
        open = 1'b1;
        lead = '0;
        hit  = 1'b0;
        lane = '0;
        for (int i = 0; i < FW; i++) begin
            if (open && vld_i[i] && (CW'(i) < req_i)) begin
                if (ubr_i[i] && !ctr_i[i] && !lr_i[i]) begin
                    hit  = 1'b1;
                    lane = LW'(i);
                    open = 1'b0;
                end else begin
                    lead = lead + CW'(1);
                end
            end else begin
                open = 1'b0;
            end
        end
        if (flush_i) begin
            lead = '0;
            hit  = 1'b0;
        end
    end

    assign wr_cnt_o    = lead;
    assign fold_o      = hit;
    assign fold_lane_o = lane;
endmodule

// File: rtl/iqf_disp_pick.sv
// Module: iqf_disp_pick
// In-order dispatch selection over the DW bottom entries. A slot fires only
// if every older slot fires, it holds an entry, its target is ready and the
// completion queue has a credit for it.
// Assumes DW does not exceed the queue depth.
module iqf_disp_pick #(
    parameter int unsigned DW  = 2,
    parameter int unsigned CW  = 3,
    parameter int unsigned CQW = 2
) (
    input  logic           flush_i,
    input  logic [CW-1:0]  occ_i,
    input  logic [DW-1:0]  rdy_i,
    input  logic [CQW-1:0] cq_free_i,
    output logic [DW-1:0]  vld_o,
    output logic [DW-1:0]  go_o,
    output logic [CW-1:0]  n_o
);
    logic chain;

    // Grant slots bottom up; the first refusal blocks all younger slots.
    always_comb begin
        chain = !flush_i;
        n_o   = '0;
        for (int k = 0; k < DW; k++) begin
            vld_o[k] = !flush_i && (occ_i > CW'(k));
            chain    = chain && vld_o[k] && rdy_i[k] && (cq_free_i > CQW'(k));
            go_o[k]  = chain;
            if (chain) n_o = n_o + CW'(1);
        end
    end
endmodule

// File: rtl/iqf_store.sv
// Module: iqf_store
// Shifting entry storage. Entry 0 is always the oldest. Each edge, the
// n_disp_i oldest entries leave, the rest move down, and wr_cnt_i new lanes
// are appended at the new top.
// Assumes the caller never asks for more room than is free.
module iqf_store
    import iqf_pkg::*;
#(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned FW    = 4,
    parameter int unsigned DW    = 2,
    parameter int unsigned CW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic [CW-1:0]       n_disp_i,
    input  logic [CW-1:0]       wr_cnt_i,
    input  word_t [FW-1:0]      lane_i,
    output logic  [CW-1:0]      occ_o,
    output word_t [DEPTH-1:0]   ents_o
);
    logic [CW-1:0] occ_q;

    // Occupancy: drop dispatched, add written; flush and reset empty it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) occ_q <= '0;
        else                   occ_q <= occ_q - n_disp_i + wr_cnt_i;
    end

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        word_t ent_q;
        word_t ent_d;

        // Pick this entry's next value: a shifted older entry or a new lane.
        always_comb begin
            int base;
            ent_d = ent_q;
            base  = int'(occ_q) - int'(n_disp_i);
            if (j < base) begin
                for (int d = 0; d <= DW; d++) begin
                    if ((int'(n_disp_i) == d) && (j + d < DEPTH))
                        ent_d = ents_o[(j + d < DEPTH) ? j + d : j];
                end
            end else begin
                for (int l = 0; l < FW; l++) begin
                    if ((j == base + l) && (l < int'(wr_cnt_i)))
                        ent_d = lane_i[l];
                end
            end
        end

        // Entry register.
        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ents_o[j] = ent_q;
    end

    assign occ_o = occ_q;
endmodule

// File: rtl/instr_queue_fold.sv
// Module: instr_queue_fold (top)
// In-order instruction queue with branch folding between fetch and dispatch.
// Requests as many lanes as are free (capped at FW), folds qualifying
// unconditional taken branches at entry, and dispatches in order from the
// DW bottom entries under completion-queue credits.
// Assumes DEPTH >= FW >= 2 and DEPTH >= DW, and that valid fetch lanes
// beyond fetch_req_o may be presented and are dropped.
module instr_queue_fold
    import iqf_pkg::*;
#(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned FW    = 4,
    parameter int unsigned DW    = 2,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned CQW  = $clog2(DW + 1),
    localparam int unsigned LW   = $clog2(FW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [FW-1:0]     fetch_vld_i,
    input  logic [FW*IW-1:0]  fetch_word_i,
    input  logic [FW-1:0]     fetch_ubr_i,
    input  logic [FW-1:0]     fetch_ctr_i,
    input  logic [FW-1:0]     fetch_lr_i,
    output logic [CW-1:0]     fetch_req_o,
    input  logic [CQW-1:0]    cq_free_i,
    input  logic [DW-1:0]     disp_rdy_i,
    output logic [DW-1:0]     disp_vld_o,
    output logic [DW*IW-1:0]  disp_word_o,
    output logic [DW-1:0]     disp_go_o,
    output logic              redirect_o,
    output logic [IW-1:0]     redirect_word_o
);
    word_t [FW-1:0]    lanes;
    word_t [DEPTH-1:0] ents;
    logic  [CW-1:0]    occ;
    logic  [CW-1:0]    wr_cnt;
    logic  [CW-1:0]    n_disp;
    logic              fold;
    logic  [LW-1:0]    fold_lane;

    // Split the flat fetch bus into lane words.
    for (genvar i = 0; i < FW; i++) begin : g_lane
        assign lanes[i] = fetch_word_i[i*IW +: IW];
    end

    // Fetch request: free slots seen this cycle, capped at the fetch width.
    always_comb begin
        fetch_req_o = CW'(min_u(DEPTH - int'(occ), FW));
    end

    iqf_fetch_scan #(.FW(FW), .CW(CW)) u_scan (
        .flush_i     (flush_i),
        .vld_i       (fetch_vld_i),
        .ubr_i       (fetch_ubr_i),
        .ctr_i       (fetch_ctr_i),
        .lr_i        (fetch_lr_i),
        .req_i       (fetch_req_o),
        .wr_cnt_o    (wr_cnt),
        .fold_o      (fold),
        .fold_lane_o (fold_lane)
    );

    iqf_disp_pick #(.DW(DW), .CW(CW), .CQW(CQW)) u_pick (
        .flush_i   (flush_i),
        .occ_i     (occ),
        .rdy_i     (disp_rdy_i),
        .cq_free_i (cq_free_i),
        .vld_o     (disp_vld_o),
        .go_o      (disp_go_o),
        .n_o       (n_disp)
    );

    iqf_store #(.DEPTH(DEPTH), .FW(FW), .DW(DW), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .n_disp_i (n_disp),
        .wr_cnt_i (wr_cnt),
        .lane_i   (lanes),
        .occ_o    (occ),
        .ents_o   (ents)
    );

    // Present the bottom entries to dispatch.
    for (genvar k = 0; k < DW; k++) begin : g_disp
        assign disp_word_o[k*IW +: IW] = ents[k];
    end

    // Redirect carries the folded branch word to the fetch path.
    assign redirect_o      = fold;
    assign redirect_word_o = lanes[fold_lane];
endmodule

// File: rtl/iqf_chk.sv
// Module: iqf_chk
// Property checker for instr_queue_fold, attached by bind below.
module iqf_chk #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned FW    = 4,
    parameter int unsigned DW    = 2,
    parameter int unsigned IW    = 32,
    parameter int unsigned CW    = 3,
    parameter int unsigned CQW   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic [CW-1:0]    fetch_req_o,
    input logic [CW-1:0]    occ,
    input logic [CW-1:0]    wr_cnt,
    input logic [DW-1:0]    disp_vld_o,
    input logic [DW-1:0]    disp_go_o,
    input logic [DW*IW-1:0] disp_word_o,
    input logic [CQW-1:0]   cq_free_i,
    input logic             redirect_o
);
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R5
    go_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_go_o[0] |-> (disp_vld_o[0] && cq_free_i != '0));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (disp_vld_o == '0 && fetch_req_o == CW'(FW)));

    // R7
    redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !flush_i);

    // R2
    full_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o == '0) |-> (flush_i || (&disp_vld_o)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && disp_go_o == '0 && wr_cnt == '0) |=> $stable(occ));

    if (DW > 1) begin : g_multi
        // R5
        go_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            disp_go_o[1] |-> disp_go_o[0]);

        // R6
        shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush_i && disp_go_o[0] && !disp_go_o[1] && disp_vld_o[1])
            |=> (flush_i || (disp_vld_o[0] &&
                 disp_word_o[IW-1:0] == $past(disp_word_o[2*IW-1:IW]))));
    end
endmodule

bind instr_queue_fold iqf_chk #(
    .DEPTH(DEPTH), .FW(FW), .DW(DW), .IW(iqf_pkg::IW), .CW(CW), .CQW(CQW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .fetch_req_o (fetch_req_o),
    .occ         (occ),
    .wr_cnt      (wr_cnt),
    .disp_vld_o  (disp_vld_o),
    .disp_go_o   (disp_go_o),
    .disp_word_o (disp_word_o),
    .cq_free_i   (cq_free_i),
    .redirect_o  (redirect_o)
);

// File: tb/instr_queue_fold_bench.sv
// Bench for instr_queue_fold: directed cases, then a long pseudo-random
// sweep, each cycle compared against an arithmetic queue model.
module instr_queue_fold_bench;
    localparam int DEPTH = 6;
    localparam int FW    = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush_i = 1'b0;
    logic [3:0]   fetch_vld_i = '0;
    logic [127:0] fetch_word_i = '0;
    logic [3:0]   fetch_ubr_i = '0;
    logic [3:0]   fetch_ctr_i = '0;
    logic [3:0]   fetch_lr_i = '0;
    logic [2:0]   fetch_req_o;
    logic [1:0]   cq_free_i = '0;
    logic [1:0]   disp_rdy_i = '0;
    logic [1:0]   disp_vld_o;
    logic [63:0]  disp_word_o;
    logic [1:0]   disp_go_o;
    logic         redirect_o;
    logic [31:0]  redirect_word_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] mq [DEPTH];
    int          mcnt = 0;
    logic [31:0] seq  = 32'h100;
    logic [31:0] rs   = 32'h1234_5678;

    always #4 clk = ~clk;

    instr_queue_fold u_instr_queue_fold (.*);

    task automatic chk(input string tag, input string ph, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): act=%h exp=%h", tag, ph, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check outputs, advance the model.
    task automatic step(input string ph, input logic [3:0] v, input logic [3:0] ub,
                        input logic [3:0] ct, input logic [3:0] lr,
                        input logic [1:0] rdy, input logic [1:0] cqf, input logic fl);
        int req, nd, lead, wr, flane, base;
        bit open, fhit, blocked;
        logic [1:0] ev, eg;
        @(negedge clk);
        fetch_vld_i = v; fetch_ubr_i = ub; fetch_ctr_i = ct; fetch_lr_i = lr;
        disp_rdy_i = rdy; cq_free_i = cqf; flush_i = fl;
        for (int l = 0; l < FW; l++) fetch_word_i[l*32 +: 32] = seq + 32'(l);
        #1;
        req = (DEPTH - mcnt < FW) ? DEPTH - mcnt : FW;
        ev[0] = !fl && mcnt > 0;
        ev[1] = !fl && mcnt > 1;
        eg[0] = ev[0] && rdy[0] && cqf >= 1;
        eg[1] = eg[0] && ev[1] && rdy[1] && cqf >= 2;
        nd = int'(eg[0]) + int'(eg[1]);
        open = 1; lead = 0; fhit = 0; flane = 0; blocked = 0;
        for (int l = 0; l < FW; l++) begin
            if (open && v[l] && l < req) begin
                if (ub[l] && !ct[l] && !lr[l]) begin fhit = 1; flane = l; open = 0; end
                else begin lead++; if (ub[l]) blocked = 1; end
            end else open = 0;
        end
        if (fl) begin fhit = 0; lead = 0; end
        wr = lead;
        chk("R2", ph, 32'(fetch_req_o), 32'(req));
        chk(fl ? "R9" : "R4", ph, 32'(disp_vld_o), 32'(ev));
        chk(fl ? "R9" : "R5", ph, 32'(disp_go_o), 32'(eg));
        chk(fl ? "R9" : (blocked ? "R8" : "R7"), ph, 32'(redirect_o), 32'(fhit));
        if (fhit) chk("R7", ph, redirect_word_o, seq + 32'(flane));
        for (int k = 0; k < 2; k++)
            if (ev[k]) chk("R6", ph, disp_word_o[k*32 +: 32], mq[k]);
        if (fl) mcnt = 0;
        else begin
            base = mcnt - nd;
            for (int j = 0; j < base; j++) mq[j] = mq[j + nd];
            for (int l = 0; l < wr; l++) mq[base + l] = seq + 32'(l);
            mcnt = base + wr;
        end
        seq = seq + 32'h10;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "reset", 32'(disp_vld_o), 32'd0);
        chk("R1", "reset", 32'(disp_go_o), 32'd0);
        chk("R1", "reset", 32'(redirect_o), 32'd0);
        chk("R1", "reset", 32'(fetch_req_o), 32'd4);
        // R3: gap at lane 1 stops acceptance after lane 0
        step("R3 sparse", 4'b1101, 4'h0, 4'h0, 4'h0, 2'b00, 2'd0, 1'b0);
        step("R3 sparse", 4'b0000, 4'h0, 4'h0, 4'h0, 2'b00, 2'd0, 1'b0);
        // R10: fill without dispatch until full, request drops to zero
        for (int i = 0; i < 4; i++)
            step("R10 fill", 4'hF, 4'h0, 4'h0, 4'h0, 2'b00, 2'd0, 1'b0);
        // R5: one credit lets one slot go, slot 1 ready alone does nothing
        step("R5 credit", 4'h0, 4'h0, 4'h0, 4'h0, 2'b11, 2'd1, 1'b0);
        step("R5 order",  4'h0, 4'h0, 4'h0, 4'h0, 2'b10, 2'd2, 1'b0);
        step("R6 drain",  4'h0, 4'h0, 4'h0, 4'h0, 2'b11, 2'd2, 1'b0);
        // R9: flush with entries present and a fetch group offered
        step("R9 flush", 4'hF, 4'h4, 4'h0, 4'h0, 2'b11, 2'd2, 1'b1);
        step("R9 after", 4'h0, 4'h0, 4'h0, 4'h0, 2'b00, 2'd0, 1'b0);
        // R7: fold at lane 2 keeps lanes 0,1 only
        step("R7 fold", 4'hF, 4'h4, 4'h0, 4'h0, 2'b00, 2'd0, 1'b0);
        step("R7 target", 4'hF, 4'h0, 4'h0, 4'h0, 2'b11, 2'd2, 1'b0);
        // R8: branch writing CTR or LR is queued, not folded
        step("R8 ctr", 4'h3, 4'h1, 4'h1, 4'h0, 2'b11, 2'd2, 1'b0);
        step("R8 lr",  4'h3, 4'h2, 4'h0, 4'h2, 2'b11, 2'd2, 1'b0);
        for (int i = 0; i < 4; i++)
            step("R8 drain", 4'h0, 4'h0, 4'h0, 4'h0, 2'b11, 2'd2, 1'b0);
        // Sweep: pseudo-random mix of groups, folds, credits and flushes
        for (int c = 0; c < 6000; c++) begin
            logic [3:0] v, ub, ct, lr;
            logic [1:0] cqf;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            v   = rs[3:0] | (rs[4] ? 4'hF : 4'h0);
            ub  = rs[7] ? (4'h1 << rs[6:5]) : 4'h0;
            ct  = (rs[8] && rs[9]) ? ub : 4'h0;
            lr  = (rs[10] && rs[11]) ? ub : 4'h0;
            cqf = (rs[16:15] == 2'd3) ? 2'd2 : rs[16:15];
            step("sweep", v, ub, ct, lr, rs[13:12] | {2{rs[14]}}, cqf, rs[22:17] == 6'd0);
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: act=%0d exp=%0d", 20000, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule